// File: doc/BRIEF.md
# Bus Bridge Quiesce Sequencer

This block takes a sub-block that talks to the rest of the chip through two asynchronous bus bridges, one on the master side and one on the slave side, and brings it into or out of service. Each bridge takes a stop request and answers with an acknowledge. A bridge reports that it has stopped by raising the acknowledge and that it is running again by dropping it. The sequencer also owns the sub-block's clock enable and its active-low reset.

Bring-up runs in this order. The reset is held while the clock runs for a set number of cycles, so the reset reaches the whole sub-block. The clock is then gated, the reset is released and the clock is turned back on. The master bridge is released next, then the slave bridge. Shutdown stops the slave bridge first and the master bridge second, then gates the clock and asserts reset. If the second handshake of either sequence times out, the bridge that was already changed is put back. The error output names the bridge that failed. A reset request runs a full shutdown followed by a full bring-up.

If a bridge is marked absent, its handshake step finishes at once. The sub-block then uses the same sequence without that bridge.

Top module: `bridge_quiesce_ctrl`

## Requirements
- R1: After reset, sub_clk_en=0, sub_rst_n=0, mst_stop_req=1, slv_stop_req=1, busy=0, done=0, error=0 and err_src=0.
- R2: A bring-up first drives sub_clk_en=1 for exactly PROP_CYC cycles while sub_rst_n=0. sub_rst_n is released only in a cycle where sub_clk_en=0.
- R3: A bring-up drops mst_stop_req before slv_stop_req, and drops each only while sub_clk_en=1 and sub_rst_n=1. On success it ends with both stop requests 0, sub_clk_en=1, sub_rst_n=1 and error=0.
- R4: A shutdown raises slv_stop_req before mst_stop_req. A stop request of 1 asks a bridge to stop, and an acknowledge of 1 means the bridge is stopped.
- R5: A successful shutdown gates sub_clk_en and only then drives sub_rst_n low. It ends with both stop requests 1 and error=0.
- R6: If the slave handshake fails during bring-up, mst_stop_req is raised again, then the clock is gated and reset is asserted. The block reports error with err_src=2'b10 (bit 1 = slave bridge).
- R7: If the master handshake fails during shutdown, slv_stop_req returns to 0 and sub_clk_en and sub_rst_n stay 1. The block reports error with err_src=2'b01 (bit 0 = master bridge).
- R8: A handshake whose acknowledge never answers fails TMO_CYC cycles after its request changed, not earlier.
- R9: A bridge whose present input is 0 completes its handshake step without waiting. A shutdown with both bridges absent raises done on the 4th cycle after the start is sampled.
- R10: start_reset runs a full shutdown (sub_rst_n goes low) and then a full bring-up with PROP_CYC propagation cycles. It produces one done pulse. Priority is start_reset over start_disable over start_enable.
- R11: Start inputs are ignored while busy=1.
- R12: done is a one-cycle pulse with busy=0. error and err_src are nonzero only together with done, and err_src is 0 or one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_enable | input | 1 | Request a bring-up |
| start_disable | input | 1 | Request a shutdown |
| start_reset | input | 1 | Request shutdown then bring-up |
| mst_present | input | 1 | Master-side bridge exists |
| slv_present | input | 1 | Slave-side bridge exists |
| mst_ack | input | 1 | Master bridge acknowledge (1 = stopped) |
| slv_ack | input | 1 | Slave bridge acknowledge (1 = stopped) |
| mst_stop_req | output | 1 | Master bridge stop request |
| slv_stop_req | output | 1 | Slave bridge stop request |
| sub_clk_en | output | 1 | Sub-block clock enable |
| sub_rst_n | output | 1 | Sub-block active-low reset |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| error | output | 1 | The finished sequence failed |
| err_src | output | 2 | Failing bridge, bit 0 master, bit 1 slave |

## Verification
Outputs are sampled on the falling edge. Cycles are numbered from the first falling edge after the start is sampled, which is cycle 1.

- **Exact timing:** with both bridges absent, a shutdown is expected to show done in exactly cycle 4. Every bring-up is expected to show exactly PROP_CYC cycles of clock-on with reset held.
- **Timeout:** the bench records the cycle in which the master stop request rose. It then requires at least TMO_CYC cycles from that point to the failing done.
- **Handshake order:** the order of the two handshakes is checked by comparing the cycles in which each stop request first changed.
- **Settled state:** the final state after each sequence is read only after done has appeared.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int unsigned BR_MST = 0;
  localparam int unsigned BR_SLV = 1;
  localparam int unsigned N_BR   = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_PROP,
    ST_REL,
    ST_CLKON,
    ST_EN_M,
    ST_EN_S,
    ST_ROLL_M,
    ST_DIS_S,
    ST_DIS_M,
    ST_ROLL_S,
    ST_OFF_RST
  } seq_state_e;
endpackage

// File: rtl/bq_handshake.sv
module bq_handshake #(
  parameter int unsigned TMO_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic want_stop,
  input  logic present,
  input  logic ack,
  output logic stop_req,
  output logic hs_done,
  output logic hs_fail
);
  localparam int unsigned CW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic          wait_q, wait_n;
  logic          stop_q, stop_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_q, done_n;
  logic          fail_q, fail_n;

  always_comb begin
    wait_n = wait_q;
    stop_n = stop_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    fail_n = 1'b0;
    if (go) begin
      stop_n = want_stop;
      cnt_n  = '0;
      if (present) wait_n = 1'b1;
      else         done_n = 1'b1;
    end else if (wait_q) begin
      if (ack == stop_q) begin
        wait_n = 1'b0;
        done_n = 1'b1;
      end else if (cnt_q == LAST) begin
        wait_n = 1'b0;
        done_n = 1'b1;
        fail_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      stop_q <= 1'b1;
      cnt_q  <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      wait_q <= wait_n;
      stop_q <= stop_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
      fail_q <= fail_n;
    end
  end

  assign stop_req = stop_q;
  assign hs_done  = done_q;
  assign hs_fail  = fail_q;
endmodule

// File: rtl/bq_sequencer.sv
module bq_sequencer
  import bq_pkg::*;
#(
  parameter int unsigned PROP_CYC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_enable,
  input  logic            start_disable,
  input  logic            start_reset,
  input  logic [N_BR-1:0] hs_done,
  input  logic [N_BR-1:0] hs_fail,
  output logic [N_BR-1:0] hs_go,
  output logic [N_BR-1:0] hs_want,
  output logic            sub_clk_en,
  output logic            sub_rst_n,
  output logic            busy,
  output logic            done,
  output logic            error,
  output logic [N_BR-1:0] err_src
);
  localparam int unsigned PW = (PROP_CYC > 1) ? $clog2(PROP_CYC) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PROP_CYC - 1);

  seq_state_e      st_q, st_n;
  logic            oprst_q, oprst_n;
  logic [PW-1:0]   prop_q, prop_n;
  logic            clk_q, clk_n;
  logic            rstn_q, rstn_n;
  logic [N_BR-1:0] src_q, src_n;
  logic            done_q, done_n;
  logic            erro_q, erro_n;
  logic [N_BR-1:0] srco_q, srco_n;
  logic            fin;

  always_comb begin
    st_n    = st_q;
    oprst_n = oprst_q;
    prop_n  = prop_q;
    clk_n   = clk_q;
    rstn_n  = rstn_q;
    src_n   = src_q;
    hs_go   = '0;
    hs_want = '0;
    fin     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_reset || start_disable) begin
          oprst_n         = start_reset;
          src_n           = '0;
          hs_go[BR_SLV]   = 1'b1;
          hs_want[BR_SLV] = 1'b1;
          st_n            = ST_DIS_S;
        end else if (start_enable) begin
          oprst_n = 1'b0;
          src_n   = '0;
          clk_n   = 1'b0;
          rstn_n  = 1'b0;
          st_n    = ST_PRE;
        end
      end
      ST_PRE: begin
        clk_n  = 1'b1;
        prop_n = '0;
        st_n   = ST_PROP;
      end
      ST_PROP: begin
        if (prop_q == PLAST) begin
          clk_n = 1'b0;
          st_n  = ST_REL;
        end else begin
          prop_n = prop_q + 1'b1;
        end
      end
      ST_REL: begin
        rstn_n = 1'b1;
        st_n   = ST_CLKON;
      end
      ST_CLKON: begin
        clk_n         = 1'b1;
        hs_go[BR_MST] = 1'b1;
        st_n          = ST_EN_M;
      end
      ST_EN_M: begin
        if (hs_done[BR_MST]) begin
          if (hs_fail[BR_MST]) begin
            src_n[BR_MST] = 1'b1;
            clk_n         = 1'b0;
            st_n          = ST_OFF_RST;
          end else begin
            hs_go[BR_SLV] = 1'b1;
            st_n          = ST_EN_S;
          end
        end
      end
      ST_EN_S: begin
        if (hs_done[BR_SLV]) begin
          if (hs_fail[BR_SLV]) begin
            src_n[BR_SLV]   = 1'b1;
            hs_go[BR_MST]   = 1'b1;
            hs_want[BR_MST] = 1'b1;
            st_n            = ST_ROLL_M;
          end else begin
            fin = 1'b1;
          end
        end
      end
      ST_ROLL_M: begin
        if (hs_done[BR_MST]) begin
          clk_n = 1'b0;
          st_n  = ST_OFF_RST;
        end
      end
      ST_DIS_S: begin
        if (hs_done[BR_SLV]) begin
          if (hs_fail[BR_SLV]) begin
            src_n[BR_SLV] = 1'b1;
            fin           = 1'b1;
          end else begin
            hs_go[BR_MST]   = 1'b1;
            hs_want[BR_MST] = 1'b1;
            st_n            = ST_DIS_M;
          end
        end
      end
      ST_DIS_M: begin
        if (hs_done[BR_MST]) begin
          if (hs_fail[BR_MST]) begin
            src_n[BR_MST] = 1'b1;
            hs_go[BR_SLV] = 1'b1;
            st_n          = ST_ROLL_S;
          end else begin
            clk_n = 1'b0;
            st_n  = ST_OFF_RST;
          end
        end
      end
      ST_ROLL_S: begin
        if (hs_done[BR_SLV]) fin = 1'b1;
      end
      ST_OFF_RST: begin
        rstn_n = 1'b0;
        if (oprst_q && (src_q == '0)) begin
          oprst_n = 1'b0;
          st_n    = ST_PRE;
        end else begin
          fin = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (fin) st_n = ST_IDLE;
    done_n = fin;
    erro_n = fin && (src_n != '0);
    srco_n = fin ? src_n : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      oprst_q <= 1'b0;
      prop_q  <= '0;
      clk_q   <= 1'b0;
      rstn_q  <= 1'b0;
      src_q   <= '0;
      done_q  <= 1'b0;
      erro_q  <= 1'b0;
      srco_q  <= '0;
    end else begin
      st_q    <= st_n;
      oprst_q <= oprst_n;
      prop_q  <= prop_n;
      clk_q   <= clk_n;
      rstn_q  <= rstn_n;
      src_q   <= src_n;
      done_q  <= done_n;
      erro_q  <= erro_n;
      srco_q  <= srco_n;
    end
  end

  assign sub_clk_en = clk_q;
  assign sub_rst_n  = rstn_q;
  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign error      = erro_q;
  assign err_src    = srco_q;
endmodule

// File: rtl/bridge_quiesce_ctrl.sv
module bridge_quiesce_ctrl
  import bq_pkg::*;
#(
  parameter int unsigned PROP_CYC = 32,
  parameter int unsigned TMO_CYC  = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_enable,
  input  logic       start_disable,
  input  logic       start_reset,
  input  logic       mst_present,
  input  logic       slv_present,
  input  logic       mst_ack,
  input  logic       slv_ack,
  output logic       mst_stop_req,
  output logic       slv_stop_req,
  output logic       sub_clk_en,
  output logic       sub_rst_n,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic [1:0] err_src
);
  logic [N_BR-1:0] go, want, hdone, hfail, pres, ackv, stopv;

  assign pres[BR_MST] = mst_present;
  assign pres[BR_SLV] = slv_present;
  assign ackv[BR_MST] = mst_ack;
  assign ackv[BR_SLV] = slv_ack;

  for (genvar b = 0; b < N_BR; b++) begin : g_br
    bq_handshake #(.TMO_CYC(TMO_CYC)) u_hs (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go[b]),
      .want_stop(want[b]),
      .present  (pres[b]),
      .ack      (ackv[b]),
      .stop_req (stopv[b]),
      .hs_done  (hdone[b]),
      .hs_fail  (hfail[b])
    );
  end

  bq_sequencer #(.PROP_CYC(PROP_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_enable (start_enable),
    .start_disable(start_disable),
    .start_reset  (start_reset),
    .hs_done      (hdone),
    .hs_fail      (hfail),
    .hs_go        (go),
    .hs_want      (want),
    .sub_clk_en   (sub_clk_en),
    .sub_rst_n    (sub_rst_n),
    .busy         (busy),
    .done         (done),
    .error        (error),
    .err_src      (err_src)
  );

  assign mst_stop_req = stopv[BR_MST];
  assign slv_stop_req = stopv[BR_SLV];
endmodule

// File: rtl/bq_checker.sv
module bq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mst_stop_req,
  input logic       slv_stop_req,
  input logic       sub_clk_en,
  input logic       sub_rst_n,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic [1:0] err_src
);
  AST_RST_REL_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sub_rst_n) |-> !sub_clk_en); // R2
  AST_RST_ASSERT_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sub_rst_n) |-> !sub_clk_en); // R5
  AST_MST_RUN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mst_stop_req) |-> (sub_clk_en && sub_rst_n)); // R3
  AST_SLV_RUN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slv_stop_req) |-> (sub_clk_en && sub_rst_n)); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (error || (err_src != 2'b00)) |-> done); // R12
  AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_src)); // R12
endmodule

bind bridge_quiesce_ctrl bq_checker u_bq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .mst_stop_req(mst_stop_req),
  .slv_stop_req(slv_stop_req),
  .sub_clk_en  (sub_clk_en),
  .sub_rst_n   (sub_rst_n),
  .busy        (busy),
  .done        (done),
  .error       (error),
  .err_src     (err_src)
);

// File: tb/bridge_quiesce_ctrl_bench.sv
`timescale 1ns/1ps
module bridge_quiesce_ctrl_bench;
  localparam int PROP = 32;
  localparam int TMO  = 50;

  logic clk, rst_n;
  logic start_enable, start_disable, start_reset;
  logic mst_present, slv_present, mst_ack, slv_ack;
  logic mst_stop_req, slv_stop_req, sub_clk_en, sub_rst_n;
  logic busy, done, error;
  logic [1:0] err_src;
  logic m_stuck, s_stuck;
  logic [2:0] mpipe, spipe;

  int checks = 0, failures = 0, wd = 0;
  int cyc, prop_cnt, done_cnt, done_cyc, m_fall, s_fall, m_rise, s_rise, rst_low;
  logic last_err;
  logic [1:0] last_src;

  bridge_quiesce_ctrl #(.PROP_CYC(PROP), .TMO_CYC(TMO)) u_bridge_quiesce_ctrl (
    .clk(clk), .rst_n(rst_n), .start_enable(start_enable),
    .start_disable(start_disable), .start_reset(start_reset),
    .mst_present(mst_present), .slv_present(slv_present),
    .mst_ack(mst_ack), .slv_ack(slv_ack), .mst_stop_req(mst_stop_req),
    .slv_stop_req(slv_stop_req), .sub_clk_en(sub_clk_en),
    .sub_rst_n(sub_rst_n), .busy(busy), .done(done), .error(error),
    .err_src(err_src));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bridge model: acknowledge follows stop request after 3 cycles unless stuck
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpipe <= 3'b111;
      spipe <= 3'b111;
    end else begin
      if (!m_stuck) mpipe <= {mpipe[1:0], mst_stop_req};
      if (!s_stuck) spipe <= {spipe[1:0], slv_stop_req};
    end
  end
  assign mst_ack = mpipe[2];
  assign slv_ack = spipe[2];

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 enable, 1 disable, 2 reset; inject_dis pulses start_disable at cycle 5
  task automatic run_op(input int kind, input bit inject_dis);
    logic pm, ps;
    @(negedge clk);
    start_enable  = (kind == 0);
    start_disable = (kind == 1);
    start_reset   = (kind == 2);
    pm = mst_stop_req; ps = slv_stop_req;
    @(negedge clk);
    start_enable = 0; start_disable = 0; start_reset = 0;
    cyc = 1; prop_cnt = 0; done_cnt = 0; done_cyc = -1;
    m_fall = -1; s_fall = -1; m_rise = -1; s_rise = -1; rst_low = 0;
    last_err = 0; last_src = 0;
    while (cyc < 3000) begin
      if (sub_clk_en && !sub_rst_n) prop_cnt++;
      if (!sub_rst_n) rst_low = 1;
      if (pm && !mst_stop_req && m_fall < 0) m_fall = cyc;
      if (ps && !slv_stop_req && s_fall < 0) s_fall = cyc;
      if (!pm && mst_stop_req && m_rise < 0) m_rise = cyc;
      if (!ps && slv_stop_req && s_rise < 0) s_rise = cyc;
      pm = mst_stop_req; ps = slv_stop_req;
      if (done) begin
        done_cnt++;
        if (done_cyc < 0) begin
          done_cyc = cyc; last_err = error; last_src = err_src;
        end
      end
      if (done_cyc > 0 && cyc >= done_cyc + 8) break;
      start_disable = inject_dis && (cyc == 5);
      @(negedge clk);
      start_disable = 0;
      cyc++;
    end
    chk(done_cyc > 0, "done seen", done_cyc, 1);
  endtask

  task automatic t_reset_state();
    chk(!sub_clk_en && !sub_rst_n, "R1 clk/rst", {sub_clk_en, sub_rst_n}, 0);
    chk(mst_stop_req && slv_stop_req, "R1 stop reqs", {mst_stop_req, slv_stop_req}, 3);
    chk(!busy && !done && !error && err_src == 0, "R1 status",
        {busy, done, error, err_src}, 0);
  endtask

  task automatic t_enable_ok();
    run_op(0, 0);
    chk(prop_cnt == PROP, "R2 propagation cycles", prop_cnt, PROP);
    chk(m_fall > 0 && s_fall > m_fall, "R3 master before slave", s_fall - m_fall, 1);
    chk(!mst_stop_req && !slv_stop_req && sub_clk_en && sub_rst_n,
        "R3 final state", {mst_stop_req, slv_stop_req, sub_clk_en, sub_rst_n}, 3);
    chk(!last_err && last_src == 0 && done_cnt == 1, "R12 ok done", done_cnt, 1);
  endtask

  task automatic t_disable_ok();
    run_op(1, 0);
    chk(s_rise > 0 && m_rise > s_rise, "R4 slave before master", m_rise - s_rise, 1);
    chk(mst_stop_req && slv_stop_req && !sub_clk_en && !sub_rst_n && !last_err,
        "R5 final state", {mst_stop_req, slv_stop_req, sub_clk_en, sub_rst_n}, 12);
  endtask

  task automatic t_enable_slv_fail();
    s_stuck = 1;
    run_op(0, 0);
    chk(last_err && last_src == 2'b10, "R6 error source", last_src, 2);
    chk(mst_stop_req && !sub_clk_en && !sub_rst_n, "R6 rollback",
        {mst_stop_req, sub_clk_en, sub_rst_n}, 4);
    s_stuck = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_disable_mst_fail();
    run_op(0, 0);
    chk(!last_err, "R3 re-enable", last_err, 0);
    m_stuck = 1;
    run_op(1, 0);
    chk(last_err && last_src == 2'b01, "R7 error source", last_src, 1);
    chk(!slv_stop_req && sub_clk_en && sub_rst_n, "R7 slave back, clk/rst kept",
        {slv_stop_req, sub_clk_en, sub_rst_n}, 3);
    chk(m_rise > 0 && (done_cyc - m_rise) >= TMO, "R8 timeout length",
        done_cyc - m_rise, TMO);
    m_stuck = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset_op();
    run_op(2, 0);
    chk(rst_low == 1, "R10 reset asserted", rst_low, 1);
    chk(prop_cnt == PROP, "R10 propagation", prop_cnt, PROP);
    chk(done_cnt == 1 && !last_err, "R10 single done", done_cnt, 1);
    chk(!mst_stop_req && !slv_stop_req && sub_clk_en && sub_rst_n, "R10 ends enabled",
        {mst_stop_req, slv_stop_req, sub_clk_en, sub_rst_n}, 3);
  endtask

  task automatic t_busy_ignore();
    run_op(0, 1);
    chk(done_cnt == 1, "R11 one done", done_cnt, 1);
    chk(!busy && sub_clk_en && sub_rst_n, "R11 disable ignored",
        {busy, sub_clk_en, sub_rst_n}, 3);
  endtask

  task automatic t_no_bridge();
    mst_present = 0; slv_present = 0;
    m_stuck = 1; s_stuck = 1;
    run_op(1, 0);
    chk(done_cyc == 4, "R9 done cycle", done_cyc, 4);
    chk(!last_err && !sub_clk_en && !sub_rst_n, "R9 off without error",
        {last_err, sub_clk_en, sub_rst_n}, 0);
    mst_present = 1; slv_present = 1;
    m_stuck = 0; s_stuck = 0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; start_enable = 0; start_disable = 0; start_reset = 0;
    mst_present = 1; slv_present = 1; m_stuck = 0; s_stuck = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_enable_ok();
    t_disable_ok();
    t_enable_slv_fail();
    t_disable_mst_fail();
    t_reset_op();
    t_busy_ignore();
    t_no_bridge();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule